// File: doc/BRIEF.md
# Serial Pattern Detector with Sticky Lockout

This block watches a one-bit serial stream, one sample per rising clock edge, and raises two single-cycle flags. The lock flag `z2` rises in the cycle whose sample completes the bit run 0,1,0. The arm flag `z1` rises in the cycle whose sample completes 1,0,0, but only while no lock event has been seen since reset. The first lock event shuts the arm flag off for good, and the lock flag keeps working. Both flags are Mealy outputs, so each one is valid in the same cycle as the bit that completes its run.

Pattern tracking is a short history window shared by both detectors. A single sticky bit holds the lockout. The only way to clear the history or the lockout is the reset input. The reset is asynchronous and active-low, and its release is synchronized inside the block.

Top module: `seq_lockout_detector`

## Requirements
- R1: `z2` is 1 in every cycle where the current sample `x` completes the run 0,1,0, listed oldest first over the last three accepted samples. Overlapping runs each fire, so 0,1,0,1,0 gives two pulses.
- R2: `z1` is 1 in every cycle where `x` completes the run 1,0,0, listed oldest first, as long as `z2` has not been 1 since the last reset.
- R3: Once `z2` has been 1, `z1` stays 0 in every later cycle until reset, even when 1,0,0 completes.
- R4: The lockout has no effect on `z2`. It keeps pulsing on every completed 0,1,0 after the lockout.
- R5: No flag fires until three samples have been accepted since reset release. A run cannot span a reset.
- R6: `z1` and `z2` are never 1 in the same cycle.
- R7: While `rst_n` is 0, both outputs are 0. Reset clears both the history and the lockout. After `rst_n` rises, the first two rising edges are still in reset, and the first sample is accepted on the third rising edge.
- R8: For the stream 1,0,0,1,1,0,0,1,0,1,0,1,0,0,1,0,1,1,0,1,0,0, `z1` is 1 only at positions 3 and 7 and `z2` only at positions 9, 11, 13, 16 and 21, with positions counted from 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one sample per edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| x | input | 1 | Serial data sample |
| z1 | output | 1 | Arm flag: 1,0,0 completed while not locked out |
| z2 | output | 1 | Lock flag: 0,1,0 completed |

## Verification
The bench builds the block with its default parameters: a three-bit window, 1,0,0 as the arm pattern and 0,1,0 as the lock pattern. With these values the fixed stream from R8 can be compared position by position. The defaults also put the lockout transition, overlapping lock runs and the locked-out arm run on the same short stream. Resets placed mid-run and after the lockout show the startup suppression and the clearing of the sticky bit. Biased random streams cover long stretches both before and after the lockout.

// File: rtl/det_pkg.sv
package det_pkg;
  // Index of each detector inside the shared window's pattern array
  localparam int IDX_ARM  = 0;
  localparam int IDX_LOCK = 1;
  localparam int NUM_PAT  = 2;

  // Hits produced by the window for one sample
  typedef struct packed {
    logic lock;
    logic arm;
  } det_hits_t;
endpackage

// File: rtl/det_rst_sync.sv
module det_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/det_window.sv
module det_window #(
  parameter int LEN  = 3,
  parameter int NPAT = 2,
  parameter logic [NPAT-1:0][LEN-1:0] PATS = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x_i,
  output logic [NPAT-1:0] match_o
);
  localparam int HW     = LEN - 1;
  localparam int FILL_W = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [FILL_W-1:0] FULL = FILL_W'(LEN - 1);

  logic [HW-1:0]     hist_q, hist_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              fill_en;
  logic [LEN-1:0]    win;
  logic              full;

  assign win     = {hist_q, x_i};
  assign full    = (fill_q == FULL);
  assign fill_en = !full;

  always_comb begin
    hist_d = win[HW-1:0];
    fill_d = fill_q;
    if (fill_en) fill_d = fill_q + FILL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_d;
      if (fill_en) fill_q <= fill_d;
    end
  end

  for (genvar g = 0; g < NPAT; g++) begin : g_match
    assign match_o[g] = full && (win == PATS[g]);
  end

  // R5
  startup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == '0) |-> (match_o == '0));
endmodule

// File: rtl/det_lockout.sv
module det_lockout (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_hit_i,
  input  logic lock_hit_i,
  output logic arm_o,
  output logic locked_o
);
  logic locked_q, locked_d, lock_en;

  assign lock_en  = lock_hit_i && !locked_q;
  assign locked_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b0;
    else if (lock_en) locked_q <= locked_d;
  end

  assign arm_o    = arm_hit_i && !locked_q;
  assign locked_o = locked_q;

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);

  // R3
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hit_i |=> locked_q);
endmodule

// File: rtl/seq_lockout_detector.sv
module seq_lockout_detector #(
  parameter int           PAT_LEN  = 3,
  parameter logic [PAT_LEN-1:0] ARM_PAT  = 3'b100,
  parameter logic [PAT_LEN-1:0] LOCK_PAT = 3'b010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x,
  output logic z1,
  output logic z2
);
  import det_pkg::*;

  localparam logic [NUM_PAT-1:0][PAT_LEN-1:0] PATS = {LOCK_PAT, ARM_PAT};

  logic               srst_n;
  logic [NUM_PAT-1:0] match;
  det_hits_t          hits;
  logic               locked;
  logic               arm_ok;

  det_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  det_window #(
    .LEN  (PAT_LEN),
    .NPAT (NUM_PAT),
    .PATS (PATS)
  ) i_window (
    .clk     (clk),
    .rst_n   (srst_n),
    .x_i     (x),
    .match_o (match)
  );

  assign hits.arm  = match[IDX_ARM];
  assign hits.lock = match[IDX_LOCK];

  det_lockout i_lockout (
    .clk        (clk),
    .rst_n      (srst_n),
    .arm_hit_i  (hits.arm),
    .lock_hit_i (hits.lock),
    .arm_o      (arm_ok),
    .locked_o   (locked)
  );

  assign z1 = arm_ok;
  assign z2 = hits.lock;

  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(z1 && z2));

  // R3
  arm_blocked_chk: assert property (@(posedge clk) disable iff (!srst_n)
    locked |-> !z1);

  // R4
  lock_after_lock_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (locked && match[IDX_LOCK]) |-> z2);
endmodule

// File: tb/test_seq_lockout_detector.sv
module test_seq_lockout_detector;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic x;
  logic z1, z2;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_lockout_detector i_seq_lockout_detector (
    .clk   (clk),
    .rst_n (rst_n),
    .x     (x),
    .z1    (z1),
    .z2    (z2)
  );

  typedef struct {
    logic  ez1;
    logic  ez2;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // Independent model state
  logic [1:0] m_hist;
  int         m_fill;
  logic       m_lock;

  task automatic check(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_hist = 2'b00;
    m_fill = 0;
    m_lock = 1'b0;
  endtask

  // Driver: applies one bit and pushes the expected flags
  task automatic drive(logic b, bit use_ref = 0, logic rz1 = 0, logic rz2 = 0);
    logic [2:0] win;
    bit   full;
    exp_t e;
    @(negedge clk);
    x    = b;
    win  = {m_hist, b};
    full = (m_fill >= 2);
    e.ez2 = full && (win == 3'b010);
    e.ez1 = full && (win == 3'b100) && !m_lock;
    if (e.ez2)                         e.req = "R1";
    else if (full && win == 3'b100)    e.req = m_lock ? "R3" : "R2";
    else if (!full)                    e.req = "R5";
    else                               e.req = m_lock ? "R4" : "R2";
    if (use_ref) begin
      e.ez1 = rz1;
      e.ez2 = rz2;
      e.req = "R8";
    end
    exp_q.push_back(e);
    if (full && win == 3'b010) m_lock = 1'b1;
    m_hist = {m_hist[0], b};
    if (m_fill < 2) m_fill++;
  endtask

  // Monitor: pops and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, "z1", z1, e.ez1);
        check(e.req, "z2", z2, e.ez2);
        check("R6", "z1&z2", z1 & z2, 1'b0);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    x     = 1'b0;
    model_clear();
    #1;
    check("R7", "z1 in reset", z1, 1'b0);
    check("R7", "z2 in reset", z2, 1'b0);
    repeat (3) @(negedge clk);
    x = 1'b1;
    #1;
    check("R7", "z1 in reset", z1, 1'b0);
    check("R7", "z2 in reset", z2, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic random_stream(int len, int pct_zero);
    for (int i = 0; i < len; i++) begin
      drive(($urandom_range(0, 99) < pct_zero) ? 1'b0 : 1'b1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [21:0] ref_x, ref_z1, ref_z2;
    rst_n = 1'b0;
    x     = 1'b0;
    model_clear();
    do_reset();

    // R8: fixed stream, index 21 is position 1
    ref_x  = 22'b1001100101010010110100;
    ref_z1 = 22'b0010001000000000000000;
    ref_z2 = 22'b0000000010101001000010;
    for (int i = 21; i >= 0; i--) drive(ref_x[i], 1, ref_z1[i], ref_z2[i]);

    // R3 R4: locked, arm run stays quiet, lock runs still fire
    drive(1); drive(0); drive(0); drive(1); drive(0); drive(1); drive(0);

    // R7: reset clears lockout, then R2 fires again
    do_reset();
    drive(1); drive(0); drive(0);

    // R2: repeated arm runs with no lock run in between
    for (int k = 0; k < 4; k++) begin
      drive(1); drive(1); drive(0); drive(0);
    end

    // R5: run split by a reset must not fire
    drive(0); drive(1);
    do_reset();
    drive(0); drive(1);

    // R1: overlapping lock runs right after reset
    do_reset();
    drive(0); drive(1); drive(0); drive(1); drive(0);

    // Random streams with different densities
    do_reset();
    random_stream(300, 50);
    do_reset();
    random_stream(300, 70);
    do_reset();
    random_stream(300, 30);

    @(negedge clk);
    #(CLK_PERIOD/2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule